// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor with Target Cache and Direction Table

This block supplies the fetch stage with a predicted next program counter every cycle. It combines two structures. The first is a small, direct-mapped target cache. Each entry holds a valid flag, the full branch address used as its tag, a target address and two prediction bits. The second is a larger table of 2-bit saturating direction counters that is indexed by PC. The fetch lookup is combinational. When the fetch PC hits a valid entry whose prediction bits say taken, the stored target comes out; in every other case the output is the sequential address, PC+4.

A later pipeline stage uses the direction table to repair a branch that the target cache did not redirect. It presents the branch PC, the target it has decoded, and whether fetch already went the taken way. If the counter for that PC says taken and fetch did not, the block raises a correcting redirect to the decoded target.

When a control instruction resolves, it is reported on the update port. The block checks the outcome against what the target cache would have predicted for that PC. On a mismatch it raises a redirect in the same cycle. The counter is always trained. The target cache receives new entries only from taken control instructions. Non-control instructions leave every structure untouched.

Top module: `nextpc_predictor`

## Requirements
- R1: `fetch_next_pc` equals the stored target when `fetch_pc` hits an entry whose prediction-bit MSB (bit 1) is 1. Otherwise it equals `fetch_pc`+4. The output is combinational in the same cycle, and `fetch_pred_taken` reports which of the two cases applies.
- R2: A lookup hits only when the entry is valid and its stored full PC equals the PC being looked up. A different PC that maps to the same entry gets PC+4.
- R3: After reset every target-cache entry is invalid and every direction counter holds 2'b01 (weakly not-taken), so all fetches return PC+4 and no correcting redirect is raised.
- R4: Direction counters saturate in the range 2'b00..2'b11: a taken outcome moves a counter up by one, a not-taken outcome moves it down by one, and bit 1 is the predicted direction. From 2'b11, a single not-taken outcome leaves the prediction at taken, and a second one flips it.
- R5: The direction counter is selected by PC bits [DIR_IDX_W+1:2], so PCs that differ only above those bits share a counter.
- R6: On a control update, a misprediction is one of the following:
  - the cache predicted not-taken and the branch was taken;
  - the cache predicted taken and the branch was not taken;
  - the cache predicted taken to a different target.

  A misprediction raises `rd_redirect` in the same cycle, with `rd_pc` set to the actual target if the branch was taken, or PC+4 if not. A correct prediction raises no redirect.
- R7: A taken control instruction that misses the target cache is allocated with its PC, its target and prediction bits 2'b10 (weakly taken). A taken instruction that hits moves the entry's bits up by one and stores the actual target.
- R8: An update with `upd_is_ctrl`=0 raises no redirect and changes neither the target cache nor the direction counters.
- R9: A not-taken control instruction that hits keeps its entry and moves the entry's bits down by one. A not-taken instruction that misses allocates nothing.
- R10: `fix_redirect` is 1 exactly when all of the following hold: `chk_valid` and `chk_is_branch` are 1, `chk_fetch_taken` is 0, and bit 1 of the direction counter for `chk_pc` is 1. `fix_pc` then equals `chk_target`.
- R11: The target-cache entry is selected by PC bits [BTB_IDX_W+1:2]. A taken allocation replaces whatever entry held that index, and leaves all other indices unchanged.
- R12: Updates are written at the clock edge that ends the update cycle. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| fetch_next_pc | output | PC_W | Predicted next PC |
| fetch_pred_taken | output | 1 | Target-cache hit with taken prediction |
| chk_valid | input | 1 | Later-stage check slot holds an instruction |
| chk_is_branch | input | 1 | That instruction is a branch |
| chk_pc | input | PC_W | PC of the instruction under check |
| chk_fetch_taken | input | 1 | Fetch already followed the taken path for it |
| chk_target | input | PC_W | Decoded branch target |
| fix_redirect | output | 1 | Correcting redirect from the direction table |
| fix_pc | output | PC_W | Address for the correcting redirect |
| upd_valid | input | 1 | Resolution report present |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_is_ctrl | input | 1 | Resolved instruction is a branch or jump |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | PC_W | Actual target |
| rd_redirect | output | 1 | Mispredict redirect |
| rd_pc | output | PC_W | Address to restart fetch from |

## Verification
The bench builds the block with PC_W=16, BTB_IDX_W=2 (four target-cache entries) and DIR_IDX_W=4 (sixteen counters). These sizes are small enough that a handful of hand-picked addresses can alias in the target cache while using separate counters, and can also share a counter. This makes eviction, tag mismatch and counter sharing all reachable with short sequences. The narrow PC keeps the expected addresses readable. The bench also keeps its own model of both tables, written from the requirements, which follows long mixed sequences of taken, not-taken, retargeted and non-control updates.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_STRONG_NT = 2'b00;
  localparam ctr2_t CTR_WEAK_NT   = 2'b01;
  localparam ctr2_t CTR_WEAK_T    = 2'b10;
  localparam ctr2_t CTR_STRONG_T  = 2'b11;

  // Saturating step of a 2-bit counter toward the observed outcome.
  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic went_taken);
    ctr2_t nxt;
    if (went_taken) nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    else            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  // Direction carried by a counter.
  function automatic logic ctr_taken(input ctr2_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/nextpc_btb.sv
module nextpc_btb
  import nextpc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  // lookup port for fetch
  input  logic [PC_W-1:0] fa_pc,
  output logic            fa_hit,
  output logic [PC_W-1:0] fa_tgt,
  output ctr2_t           fa_bits,
  // lookup port for resolution
  input  logic [PC_W-1:0] ub_pc,
  output logic            ub_hit,
  output logic [PC_W-1:0] ub_tgt,
  output ctr2_t           ub_bits,
  // single write port
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_tgt,
  input  ctr2_t           wr_bits
);
  localparam int DEPTH = 1 << IDX_W;

  logic            ent_v    [DEPTH];
  logic [PC_W-1:0] ent_tag  [DEPTH];
  logic [PC_W-1:0] ent_tgt  [DEPTH];
  ctr2_t           ent_bits [DEPTH];

  logic [IDX_W-1:0] fa_idx, ub_idx, wr_idx;

  assign fa_idx = fa_pc[IDX_W+1:2];
  assign ub_idx = ub_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];

  assign fa_hit  = ent_v[fa_idx] && (ent_tag[fa_idx] == fa_pc);
  assign fa_tgt  = ent_tgt[fa_idx];
  assign fa_bits = ent_bits[fa_idx];

  assign ub_hit  = ent_v[ub_idx] && (ent_tag[ub_idx] == ub_pc);
  assign ub_tgt  = ent_tgt[ub_idx];
  assign ub_bits = ent_bits[ub_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_v[i] <= 1'b0;
    end else if (wr_en) begin
      ent_v[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_tag[wr_idx]  <= wr_pc;
      ent_tgt[wr_idx]  <= wr_tgt;
      ent_bits[wr_idx] <= wr_bits;
    end
  end

endmodule

// File: rtl/nextpc_dir_table.sv
module nextpc_dir_table
  import nextpc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] ca_pc,
  output ctr2_t           ca_ctr,
  input  logic [PC_W-1:0] ub_pc,
  output ctr2_t           ub_ctr,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  ctr2_t           wr_val
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t ctr_mem [DEPTH];

  assign ca_ctr = ctr_mem[ca_pc[IDX_W+1:2]];
  assign ub_ctr = ctr_mem[ub_pc[IDX_W+1:2]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      ctr_mem[wr_pc[IDX_W+1:2]] <= wr_val;
    end
  end

endmodule

// File: rtl/nextpc_resolve.sv
module nextpc_resolve
  import nextpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_is_ctrl,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            c_hit,
  input  logic [PC_W-1:0] c_tgt,
  input  ctr2_t           c_bits,
  input  ctr2_t           d_ctr,
  output logic            mispredict,
  output logic [PC_W-1:0] restart_pc,
  output logic            btb_wr_en,
  output logic [PC_W-1:0] btb_wr_tgt,
  output ctr2_t           btb_wr_bits,
  output logic            dir_wr_en,
  output ctr2_t           dir_wr_val
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic is_ctrl_upd;
  logic cache_said_taken;

  assign is_ctrl_upd      = upd_valid && upd_is_ctrl;
  assign cache_said_taken = c_hit && ctr_taken(c_bits);

  always_comb begin
    if (cache_said_taken)
      mispredict = is_ctrl_upd && (!upd_taken || (upd_target != c_tgt));
    else
      mispredict = is_ctrl_upd && upd_taken;
  end

  assign restart_pc = upd_taken ? upd_target : (upd_pc + STEP);

  // Entry written on any hit (bits move) or a taken miss (allocation).
  assign btb_wr_en   = is_ctrl_upd && (c_hit || upd_taken);
  assign btb_wr_tgt  = upd_taken ? upd_target : c_tgt;
  assign btb_wr_bits = c_hit ? ctr_step(c_bits, upd_taken) : CTR_WEAK_T;

  assign dir_wr_en  = is_ctrl_upd;
  assign dir_wr_val = ctr_step(d_ctr, upd_taken);

endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor
  import nextpc_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int BTB_IDX_W = 4,
  parameter int DIR_IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] fetch_next_pc,
  output logic            fetch_pred_taken,
  input  logic            chk_valid,
  input  logic            chk_is_branch,
  input  logic [PC_W-1:0] chk_pc,
  input  logic            chk_fetch_taken,
  input  logic [PC_W-1:0] chk_target,
  output logic            fix_redirect,
  output logic [PC_W-1:0] fix_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_is_ctrl,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            rd_redirect,
  output logic [PC_W-1:0] rd_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  // named internal events, also observed by the checker
  logic            f_hit;
  logic [PC_W-1:0] f_tgt;
  ctr2_t           f_bits;
  logic            u_hit;
  logic [PC_W-1:0] u_tgt;
  ctr2_t           u_bits;
  ctr2_t           chk_ctr;
  ctr2_t           u_ctr;
  logic            upd_mispredict;
  logic [PC_W-1:0] upd_restart;
  logic            btb_wr_en;
  logic [PC_W-1:0] btb_wr_tgt;
  ctr2_t           btb_wr_bits;
  logic            dir_wr_en;
  ctr2_t           dir_wr_val;

  nextpc_btb #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) btb_u (
    .clk     (clk),
    .rst_n   (rst_n),
    .fa_pc   (fetch_pc),
    .fa_hit  (f_hit),
    .fa_tgt  (f_tgt),
    .fa_bits (f_bits),
    .ub_pc   (upd_pc),
    .ub_hit  (u_hit),
    .ub_tgt  (u_tgt),
    .ub_bits (u_bits),
    .wr_en   (btb_wr_en),
    .wr_pc   (upd_pc),
    .wr_tgt  (btb_wr_tgt),
    .wr_bits (btb_wr_bits)
  );

  nextpc_dir_table #(.PC_W(PC_W), .IDX_W(DIR_IDX_W)) dir_u (
    .clk    (clk),
    .rst_n  (rst_n),
    .ca_pc  (chk_pc),
    .ca_ctr (chk_ctr),
    .ub_pc  (upd_pc),
    .ub_ctr (u_ctr),
    .wr_en  (dir_wr_en),
    .wr_pc  (upd_pc),
    .wr_val (dir_wr_val)
  );

  nextpc_resolve #(.PC_W(PC_W)) res_u (
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_is_ctrl (upd_is_ctrl),
    .upd_taken   (upd_taken),
    .upd_target  (upd_target),
    .c_hit       (u_hit),
    .c_tgt       (u_tgt),
    .c_bits      (u_bits),
    .d_ctr       (u_ctr),
    .mispredict  (upd_mispredict),
    .restart_pc  (upd_restart),
    .btb_wr_en   (btb_wr_en),
    .btb_wr_tgt  (btb_wr_tgt),
    .btb_wr_bits (btb_wr_bits),
    .dir_wr_en   (dir_wr_en),
    .dir_wr_val  (dir_wr_val)
  );

  assign fetch_pred_taken = f_hit && ctr_taken(f_bits);
  assign fetch_next_pc    = fetch_pred_taken ? f_tgt : (fetch_pc + STEP);

  assign fix_redirect = chk_valid && chk_is_branch && !chk_fetch_taken && ctr_taken(chk_ctr);
  assign fix_pc       = chk_target;

  assign rd_redirect = upd_mispredict;
  assign rd_pc       = upd_restart;

endmodule

// File: rtl/nextpc_predictor_chk.sv
module nextpc_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            upd_valid,
  input logic            upd_is_ctrl,
  input logic            upd_taken,
  input logic            rd_redirect,
  input logic            btb_wr_en,
  input logic            u_hit,
  input logic            dir_wr_en,
  input logic            chk_valid,
  input logic            chk_fetch_taken,
  input logic            fix_redirect,
  input logic            fetch_pred_taken,
  input logic            f_hit
);
  // R6
  redirect_needs_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_redirect |-> (upd_valid && upd_is_ctrl));

  // R8
  nonctrl_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_is_ctrl) |-> (!btb_wr_en && !dir_wr_en && !rd_redirect));

  // R9
  nt_miss_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_is_ctrl && !upd_taken && !u_hit) |-> !btb_wr_en);

  // R10
  fix_only_when_fetch_fell_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_redirect |-> (chk_valid && !chk_fetch_taken));

  // R1
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pred_taken |-> f_hit);

  // R3
  first_cycle_empty_chk: assert property (@(posedge clk)
    (!$past(rst_n) && rst_n) |-> !fetch_pred_taken);

endmodule

bind nextpc_predictor nextpc_predictor_chk #(.PC_W(PC_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .upd_valid        (upd_valid),
  .upd_is_ctrl      (upd_is_ctrl),
  .upd_taken        (upd_taken),
  .rd_redirect      (rd_redirect),
  .btb_wr_en        (btb_wr_en),
  .u_hit            (u_hit),
  .dir_wr_en        (dir_wr_en),
  .chk_valid        (chk_valid),
  .chk_fetch_taken  (chk_fetch_taken),
  .fix_redirect     (fix_redirect),
  .fetch_pred_taken (fetch_pred_taken),
  .f_hit            (f_hit)
);

// File: tb/nextpc_predictor_tb.sv
module nextpc_predictor_tb_top;
  localparam int PC_W = 16;
  localparam int BI   = 2;
  localparam int DI   = 4;
  localparam int NV   = 16;

  typedef struct packed {
    logic [15:0] pc;
    logic        ctrl;
    logic        tk;
    logic [15:0] tgt;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h0100, 1'b1, 1'b1, 16'h0040},
    '{16'h0100, 1'b1, 1'b1, 16'h0040},
    '{16'h0100, 1'b1, 1'b0, 16'h0040},
    '{16'h0100, 1'b1, 1'b1, 16'h0040},
    '{16'h0110, 1'b1, 1'b1, 16'h0500},
    '{16'h0100, 1'b1, 1'b1, 16'h0040},
    '{16'h0204, 1'b1, 1'b1, 16'h0300},
    '{16'h0204, 1'b1, 1'b1, 16'h0380},
    '{16'h0204, 1'b1, 1'b1, 16'h0380},
    '{16'h0100, 1'b0, 1'b1, 16'h0700},
    '{16'h0140, 1'b1, 1'b0, 16'h0600},
    '{16'h0140, 1'b1, 1'b1, 16'h0600},
    '{16'h0110, 1'b1, 1'b0, 16'h0500},
    '{16'h0140, 1'b1, 1'b1, 16'h0600},
    '{16'h0100, 1'b1, 1'b0, 16'h0040},
    '{16'h0204, 1'b1, 1'b0, 16'h0300}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [PC_W-1:0] fetch_next_pc;
  logic            fetch_pred_taken;
  logic            chk_valid = 1'b0;
  logic            chk_is_branch = 1'b0;
  logic [PC_W-1:0] chk_pc = '0;
  logic            chk_fetch_taken = 1'b0;
  logic [PC_W-1:0] chk_target = '0;
  logic            fix_redirect;
  logic [PC_W-1:0] fix_pc;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_is_ctrl = 1'b0;
  logic            upd_taken = 1'b0;
  logic [PC_W-1:0] upd_target = '0;
  logic            rd_redirect;
  logic [PC_W-1:0] rd_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nextpc_predictor #(.PC_W(PC_W), .BTB_IDX_W(BI), .DIR_IDX_W(DI)) dut_i (.*);

  // bench-side model of both tables, written from the requirements
  logic        m_v    [1<<BI];
  logic [15:0] m_tag  [1<<BI];
  logic [15:0] m_tgt  [1<<BI];
  logic [1:0]  m_bits [1<<BI];
  logic [1:0]  m_dir  [1<<DI];

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic m_hit(input logic [15:0] pc);
    return m_v[pc[BI+1:2]] && (m_tag[pc[BI+1:2]] == pc);
  endfunction

  function automatic logic [15:0] m_fetch(input logic [15:0] pc);
    if (m_hit(pc) && m_bits[pc[BI+1:2]][1]) return m_tgt[pc[BI+1:2]];
    return pc + 16'd4;
  endfunction

  function automatic logic m_misp(input vec_t v);
    logic pt;
    if (!v.ctrl) return 1'b0;
    pt = m_hit(v.pc) && m_bits[v.pc[BI+1:2]][1];
    if (pt) return !v.tk || (v.tgt != m_tgt[v.pc[BI+1:2]]);
    return v.tk;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < (1<<BI); i++) m_v[i] = 1'b0;
    for (int i = 0; i < (1<<DI); i++) m_dir[i] = 2'b01;
  endtask

  task automatic m_apply(input vec_t v);
    int bi;
    bi = int'(v.pc[BI+1:2]);
    if (!v.ctrl) return;
    if (m_hit(v.pc)) begin
      m_bits[bi] = sat(m_bits[bi], v.tk);
      if (v.tk) m_tgt[bi] = v.tgt;
    end else if (v.tk) begin
      m_v[bi] = 1'b1; m_tag[bi] = v.pc; m_tgt[bi] = v.tgt; m_bits[bi] = 2'b10;
    end
    m_dir[v.pc[DI+1:2]] = sat(m_dir[v.pc[DI+1:2]], v.tk);
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_valid = 1'b0; chk_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_reset();
  endtask

  // drive one update at a falling edge, check the redirect, let it commit
  task automatic do_update(input vec_t v, input string tag);
    logic em;
    logic [15:0] ep;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = v.pc; upd_is_ctrl = v.ctrl;
    upd_taken = v.tk; upd_target = v.tgt;
    em = m_misp(v);
    ep = v.tk ? v.tgt : v.pc + 16'd4;
    #1;
    check({tag, " redirect"}, 32'(rd_redirect), 32'(em));
    if (em) check({tag, " rd_pc"}, 32'(rd_pc), 32'(ep));
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    m_apply(v);
  endtask

  task automatic probe_fetch(input logic [15:0] pc, input logic [15:0] exp, input string tag);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check(tag, 32'(fetch_next_pc), 32'(exp));
  endtask

  task automatic probe_fix(input logic [15:0] pc, input logic exp, input string tag);
    @(negedge clk);
    chk_valid = 1'b1; chk_is_branch = 1'b1; chk_fetch_taken = 1'b0;
    chk_pc = pc; chk_target = 16'h0ABC;
    #1;
    check(tag, 32'(fix_redirect), 32'(exp));
    if (exp) check({tag, " fix_pc"}, 32'(fix_pc), 32'h0ABC);
    chk_valid = 1'b0;
  endtask

  function automatic vec_t mk(input logic [15:0] pc, input logic c, input logic t,
                              input logic [15:0] g);
    vec_t v;
    v.pc = pc; v.ctrl = c; v.tk = t; v.tgt = g;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();

    // R3: reset state
    probe_fetch(16'h0100, 16'h0104, "R3 fetch after reset");
    probe_fetch(16'h0ffc, 16'h1000, "R3 fetch after reset hi");
    probe_fix(16'h0100, 1'b0, "R3 counters weakly not-taken");

    // vector walk against the bench model: R1 R2 R6 R7 R8 R9 R10 R11 R12
    for (int k = 0; k < NV; k++) begin
      probe_fetch(VECS[k].pc, m_fetch(VECS[k].pc), "R1 fetch prediction");
      probe_fix(VECS[k].pc, m_dir[VECS[k].pc[DI+1:2]][1], "R10 later-stage fix");
      do_update(VECS[k], "R6 resolve");
      probe_fetch(VECS[k].pc, m_fetch(VECS[k].pc), "R12 fetch after update");
      probe_fetch(16'h0110, m_fetch(16'h0110), "R2 alias probe");
    end

    // R7: fresh allocation is weakly taken
    do_reset();
    do_update(mk(16'h0300, 1, 1, 16'h0900), "R7 alloc");
    probe_fetch(16'h0300, 16'h0900, "R7 allocated entry predicts taken");
    do_update(mk(16'h0300, 1, 0, 16'h0900), "R7 one nt");
    probe_fetch(16'h0300, 16'h0304, "R7 weak entry flips after one nt");

    // R9: hit on strong entry, not taken keeps entry, one step down
    do_update(mk(16'h0300, 1, 1, 16'h0900), "R9 retrain");
    do_update(mk(16'h0300, 1, 1, 16'h0900), "R9 retrain2");
    do_update(mk(16'h0300, 1, 0, 16'h0900), "R9 nt hit");
    probe_fetch(16'h0300, 16'h0900, "R9 entry kept after nt");
    do_update(mk(16'h0318, 1, 0, 16'h0a00), "R9 nt miss");
    probe_fetch(16'h0318, 16'h031c, "R9 nt miss not allocated");

    // R11: other index untouched by allocation
    do_update(mk(16'h0304, 1, 1, 16'h0b00), "R11 alloc idx1");
    probe_fetch(16'h0300, 16'h0900, "R11 idx0 untouched");
    probe_fetch(16'h0304, 16'h0b00, "R11 idx1 allocated");

    // R8: non-control update ignored
    do_update(mk(16'h0300, 0, 0, 16'h0c00), "R8 nonctrl");
    probe_fetch(16'h0300, 16'h0900, "R8 entry unchanged");
    probe_fix(16'h0300, m_dir[4'h0][1], "R8 counter unchanged");

    // R4 and R5: counter hysteresis and shared index
    do_reset();
    do_update(mk(16'h0208, 1, 1, 16'h0400), "R4 t1");
    probe_fix(16'h0208, 1'b1, "R4 counter now taken");
    do_update(mk(16'h0208, 1, 1, 16'h0400), "R4 t2");
    do_update(mk(16'h0208, 1, 1, 16'h0400), "R4 t3 saturate");
    probe_fix(16'h0248, 1'b1, "R5 shared counter index");
    probe_fix(16'h020c, 1'b0, "R5 neighbour counter untouched");
    do_update(mk(16'h0208, 1, 0, 16'h0400), "R4 n1");
    probe_fix(16'h0208, 1'b1, "R4 one wrong keeps taken");
    do_update(mk(16'h0208, 1, 0, 16'h0400), "R4 n2");
    probe_fix(16'h0208, 1'b0, "R4 two wrong flips");

    // R10: fetch already taken suppresses fix
    do_update(mk(16'h0208, 1, 1, 16'h0400), "R10 retrain");
    @(negedge clk);
    chk_valid = 1'b1; chk_is_branch = 1'b1; chk_fetch_taken = 1'b1; chk_pc = 16'h0208;
    #1;
    check("R10 fetch-taken suppresses fix", 32'(fix_redirect), 32'd0);
    chk_fetch_taken = 1'b0; chk_is_branch = 1'b0;
    #1;
    check("R10 non-branch suppresses fix", 32'(fix_redirect), 32'd0);
    chk_valid = 1'b0;

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule